// File: doc/BRIEF.md
# Packet Timestamp Capture Store

This block keeps a small table of 40-bit packet timestamps. Each entry belongs to one (port, slot) pair. When the packet logic next to it raises a capture request naming a port and a slot, the block copies the low 40 bits of the free-running time counter into that entry in the same clock edge and marks the entry valid. The packet logic detects packets and picks slots. The time counter is an input.

The host sees every entry as two 32-bit words, one in a low bank and one in a high bank. The low word holds timestamp bits [31:0]. The high word holds timestamp bits [39:32], the valid flag and an overrun flag. The overrun flag records that a capture landed on an entry that still held an unread stamp. The host releases an entry by writing zero to its words. Writes of any other value are ignored, so the table cannot be corrupted by stray writes.

Top module: `tsmem_capture_store`

## Requirements
- R1: After reset every entry reads zero in both words and `any_overrun` is 0.
- R2: A capture request with `cap_en`=1 stores the stamp into entry (cap_port, cap_slot) and sets its valid flag at the same clock edge.
- R3: The host address is {bank, port, slot}. The top bit selects the bank (0 = low word, 1 = high word). The next PORT_W bits give the port and the lowest SLOT_W bits give the slot. With the default sizes the address is 6 bits: bank at bit 5, port at bits 4:3, slot at bits 2:0.
- R4: A read issued with `host_rd` returns data on `host_rdata` one cycle later, and that value is held until the next read. The low word is stamp[31:0]. The high word carries stamp[39:32] in bits 7:0, valid in bit 8, overrun in bit 9, and zeros in bits 31:10.
- R5: Only bits [39:0] of `cap_timer` are stored; higher bits have no effect.
- R6: A capture into an entry that is already valid overwrites the stamp and sets that entry's overrun flag. The flag is sticky until the high word is cleared. `any_overrun` is 1 while any entry's overrun flag is set.
- R7: Writing zero to a low word clears stamp[31:0] and leaves the high word, including valid, unchanged.
- R8: Writing zero to a high word clears stamp[39:32], the valid flag and the overrun flag. A capture that follows a clear does not raise overrun.
- R9: A host write with a nonzero data value changes no entry.
- R10: When a capture and a zero write hit the same entry in the same cycle, the capture wins. The entry holds the new stamp and is valid.
- R11: A capture or a clear touches only its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture request strobe |
| cap_port | input | PORT_W | Port number of the capture |
| cap_slot | input | SLOT_W | Slot index of the capture |
| cap_timer | input | TIMER_W | Free-running time counter |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1+PORT_W+SLOT_W | Host word address {bank, port, slot} |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| any_overrun | output | 1 | OR of all entry overrun flags |

## Verification
Captures are driven at interior and extreme (port, slot) pairs with timer patterns whose upper 24 bits are junk. This separates correct truncation and placement from writes to a neighbouring entry or a swapped bank. A second capture onto a live entry, then captures after partial and full clears, separates sticky overrun from a flag that tracks valid. Zero and nonzero writes to each bank show which word a clear really reaches. A capture and a clear on one entry in the same cycle pins down the priority.

// File: rtl/tsmem_pkg.sv
package tsmem_pkg;
    localparam int TS_W    = 40;
    localparam int WORD_W  = 32;
    localparam int HI_W    = TS_W - WORD_W;
    localparam int PAD_W   = WORD_W - HI_W - 2;

    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;

    typedef struct packed {
        logic [TS_W-1:0] stamp;
        logic            valid;
        logic            ovr;
    } slot_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } rd_t;
endpackage

// File: rtl/tsmem_addr_dec.sv
module tsmem_addr_dec
    import tsmem_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W:0]   addr,
    output bank_e            bank,
    output logic [IDX_W-1:0] idx
);
    // top bit picks the word bank, the rest is {port, slot}
    assign bank = bank_e'(addr[IDX_W]);
    assign idx  = addr[IDX_W-1:0];
endmodule

// File: rtl/tsmem_entry.sv
module tsmem_entry
    import tsmem_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_hit,
    input  logic [TS_W-1:0] cap_stamp,
    input  logic            clr_lo,
    input  logic            clr_hi,
    output slot_t           slot_o
);
    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_hit) begin
            // a capture always wins over a clear of the same entry
            st_d.stamp = cap_stamp;
            st_d.valid = 1'b1;
            st_d.ovr   = st_q.ovr | st_q.valid;
        end else begin
            if (clr_lo) begin
                st_d.stamp[WORD_W-1:0] = '0;
            end
            if (clr_hi) begin
                st_d.stamp[TS_W-1:WORD_W] = '0;
                st_d.valid = 1'b0;
                st_d.ovr   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q;
endmodule

// File: rtl/tsmem_rd_port.sv
module tsmem_rd_port
    import tsmem_pkg::*;
#(
    parameter int IDX_W = 5,
    localparam int MAP  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    input  slot_t             slots_i [MAP],
    output logic [WORD_W-1:0] rdata
);
    rd_t   rd_d, rd_q;
    slot_t sel;

    always_comb begin
        rd_d = rd_q;
        sel  = slots_i[idx];
        if (host_rd) begin
            if (bank == BANK_HI) begin
                rd_d.word = {{PAD_W{1'b0}}, sel.ovr, sel.valid, sel.stamp[TS_W-1:WORD_W]};
            end else begin
                rd_d.word = sel.stamp[WORD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.word;
endmodule

// File: rtl/tsmem_capture_store.sv
module tsmem_capture_store
    import tsmem_pkg::*;
#(
    parameter int PORTS     = 4,
    parameter int SLOTS     = 8,
    parameter int TIMER_W   = 64,
    localparam int PORT_W   = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int IDX_W    = PORT_W + SLOT_W,
    localparam int ADDR_W   = IDX_W + 1,
    localparam int SPAN     = 1 << SLOT_W,
    localparam int MAP      = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [PORT_W-1:0]  cap_port,
    input  logic [SLOT_W-1:0]  cap_slot,
    input  logic [TIMER_W-1:0] cap_timer,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    output logic               any_overrun
);
    bank_e              bank;
    logic [IDX_W-1:0]   h_idx;
    logic [IDX_W-1:0]   cap_idx;
    logic               wr_zero;
    slot_t              slots [MAP];
    logic [MAP-1:0]     valid_vec;
    logic [MAP-1:0]     ovr_vec;
    logic [MAP*TS_W-1:0] stamp_flat;

    assign cap_idx = {cap_port, cap_slot};
    assign wr_zero = host_wr && (host_wdata == '0);

    tsmem_addr_dec #(.IDX_W(IDX_W)) u_dec (
        .addr (host_addr),
        .bank (bank),
        .idx  (h_idx)
    );

    for (genvar gi = 0; gi < MAP; gi++) begin : g_slot
        localparam int GP = gi / SPAN;
        localparam int GS = gi % SPAN;
        if (GP < PORTS && GS < SLOTS) begin : g_live
            tsmem_entry u_entry (
                .clk       (clk),
                .rst_n     (rst_n),
                .cap_hit   (cap_en && (cap_idx == IDX_W'(gi))),
                .cap_stamp (cap_timer[TS_W-1:0]),
                .clr_lo    (wr_zero && (bank == BANK_LO) && (h_idx == IDX_W'(gi))),
                .clr_hi    (wr_zero && (bank == BANK_HI) && (h_idx == IDX_W'(gi))),
                .slot_o    (slots[gi])
            );
        end else begin : g_hole
            // address holes from non power-of-two sizes read as zero
            assign slots[gi] = '0;
        end
        assign valid_vec[gi] = slots[gi].valid;
        assign ovr_vec[gi]   = slots[gi].ovr;
        assign stamp_flat[gi*TS_W +: TS_W] = slots[gi].stamp;
    end

    if (TIMER_W > TS_W) begin : g_timer_top
        logic unused_timer_top;
        assign unused_timer_top = ^cap_timer[TIMER_W-1:TS_W];
    end

    tsmem_rd_port #(.IDX_W(IDX_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_rd (host_rd),
        .bank    (bank),
        .idx     (h_idx),
        .slots_i (slots),
        .rdata   (host_rdata)
    );

    assign any_overrun = |ovr_vec;
endmodule

// File: rtl/tsmem_capture_store_chk.sv
module tsmem_capture_store_chk
    import tsmem_pkg::*;
#(
    parameter int PORTS  = 4,
    parameter int SLOTS  = 8,
    parameter int PORT_W = 2,
    parameter int SLOT_W = 3,
    parameter int IDX_W  = 5,
    parameter int MAP    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cap_en,
    input logic [PORT_W-1:0]   cap_port,
    input logic [SLOT_W-1:0]   cap_slot,
    input logic [TS_W-1:0]     cap_stamp,
    input logic                host_wr,
    input logic                host_rd,
    input logic [IDX_W:0]      host_addr,
    input logic [WORD_W-1:0]   host_wdata,
    input logic [WORD_W-1:0]   host_rdata,
    input logic [MAP-1:0]      valid_vec,
    input logic [MAP-1:0]      ovr_vec,
    input logic [MAP*TS_W-1:0] stamp_flat
);
    logic [IDX_W-1:0] c_idx;
    logic [IDX_W-1:0] a_idx;
    logic             a_hi;
    logic             c_live;
    logic             unused_rd_lo;

    assign c_idx  = {cap_port, cap_slot};
    assign a_idx  = host_addr[IDX_W-1:0];
    assign a_hi   = host_addr[IDX_W];
    assign c_live = cap_en && (int'(cap_port) < PORTS) && (int'(cap_slot) < SLOTS);
    assign unused_rd_lo = ^host_rdata[HI_W+1:0];

    assert_cap_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_live |=> valid_vec[$past(c_idx)]);

    assert_cap_stamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        c_live |=> stamp_flat[int'($past(c_idx))*TS_W +: TS_W] == $past(cap_stamp));

    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_live && valid_vec[c_idx]) |=> ovr_vec[$past(c_idx)]);

    assert_clear_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && a_hi && host_wdata == '0 && !(cap_en && c_idx == a_idx))
        |=> (!valid_vec[$past(a_idx)] && !ovr_vec[$past(a_idx)]));

    assert_nonzero_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata != '0 && !cap_en)
        |=> (valid_vec == $past(valid_vec) && stamp_flat == $past(stamp_flat)));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && a_hi) |=> host_rdata[WORD_W-1:HI_W+2] == '0);
endmodule

bind tsmem_capture_store tsmem_capture_store_chk #(
    .PORTS  (PORTS),
    .SLOTS  (SLOTS),
    .PORT_W (PORT_W),
    .SLOT_W (SLOT_W),
    .IDX_W  (IDX_W),
    .MAP    (MAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .cap_port   (cap_port),
    .cap_slot   (cap_slot),
    .cap_stamp  (cap_timer[39:0]),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .valid_vec  (valid_vec),
    .ovr_vec    (ovr_vec),
    .stamp_flat (stamp_flat)
);

// File: tb/tsmem_capture_store_bench.sv
module tsmem_capture_store_bench;
    localparam int PORT_W = 2;
    localparam int SLOT_W = 3;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cap_en = 1'b0;
    logic [PORT_W-1:0] cap_port = '0;
    logic [SLOT_W-1:0] cap_slot = '0;
    logic [63:0]       cap_timer = '0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              any_overrun;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    tsmem_capture_store u_tsmem_capture_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .cap_port    (cap_port),
        .cap_slot    (cap_slot),
        .cap_timer   (cap_timer),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .any_overrun (any_overrun)
    );

    // R3 address layout: {bank, port[1:0], slot[2:0]}
    function automatic logic [ADDR_W-1:0] lo_a(input int p, input int s);
        return {1'b0, 2'(p), 3'(s)};
    endfunction
    function automatic logic [ADDR_W-1:0] hi_a(input int p, input int s);
        return {1'b1, 2'(p), 3'(s)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic cap(input int p, input int s, input logic [63:0] t);
        @(negedge clk);
        cap_en = 1'b1; cap_port = 2'(p); cap_slot = 3'(s); cap_timer = t;
        @(negedge clk);
        cap_en = 1'b0; cap_timer = '0;
    endtask

    task automatic expect_entry(input string req, input int p, input int s,
                                input logic [31:0] lo, input logic [31:0] hi);
        logic [31:0] d;
        rd(lo_a(p, s), d); check(req, $sformatf("p%0d s%0d low", p, s), d, lo);
        rd(hi_a(p, s), d); check(req, $sformatf("p%0d s%0d high", p, s), d, hi);
    endtask

    task automatic t_reset();
        expect_entry("R1", 0, 0, 32'h0, 32'h0);
        expect_entry("R1", 3, 7, 32'h0, 32'h0);
        check("R1", "any_overrun", {31'b0, any_overrun}, 32'h0);
    endtask

    task automatic t_capture_basic();
        // upper timer bits are junk and must be dropped (R5)
        cap(1, 3, 64'hFFFF_FF5A_CAFE_0123);
        expect_entry("R2 R4 R5", 1, 3, 32'hCAFE_0123, 32'h0000_015A);
    endtask

    task automatic t_isolation();
        cap(2, 3, 64'hABCD_0011_2233_4455);
        expect_entry("R3 R11", 2, 3, 32'h2233_4455, 32'h0000_0111);
        expect_entry("R11", 1, 3, 32'hCAFE_0123, 32'h0000_015A);
        expect_entry("R3 R11", 1, 4, 32'h0, 32'h0);
    endtask

    task automatic t_read_hold();
        logic [31:0] d;
        rd(lo_a(2, 3), d);
        repeat (3) @(negedge clk);
        check("R4", "rdata held", host_rdata, 32'h2233_4455);
    endtask

    task automatic t_overrun();
        check("R6", "any_overrun before", {31'b0, any_overrun}, 32'h0);
        cap(1, 3, 64'h0000_0077_0BAD_F00D);
        check("R6", "any_overrun after", {31'b0, any_overrun}, 32'h1);
        expect_entry("R6", 1, 3, 32'h0BAD_F00D, 32'h0000_0377);
    endtask

    task automatic t_nonzero_write();
        wr(hi_a(1, 3), 32'h0000_0001);
        wr(lo_a(1, 3), 32'hFFFF_FFFF);
        expect_entry("R9", 1, 3, 32'h0BAD_F00D, 32'h0000_0377);
        check("R9", "any_overrun", {31'b0, any_overrun}, 32'h1);
    endtask

    task automatic t_clear_lo();
        wr(lo_a(1, 3), 32'h0);
        expect_entry("R7", 1, 3, 32'h0, 32'h0000_0377);
    endtask

    task automatic t_clear_hi();
        wr(hi_a(1, 3), 32'h0);
        expect_entry("R8", 1, 3, 32'h0, 32'h0);
        check("R8", "any_overrun cleared", {31'b0, any_overrun}, 32'h0);
        expect_entry("R8 R11", 2, 3, 32'h2233_4455, 32'h0000_0111);
        cap(1, 3, 64'h0000_0001_0000_0002);
        expect_entry("R8", 1, 3, 32'h0000_0002, 32'h0000_0101);
    endtask

    task automatic t_boundary();
        cap(3, 7, 64'h1234_00FF_FFFF_FFFF);
        expect_entry("R2 R3", 3, 7, 32'hFFFF_FFFF, 32'h0000_01FF);
        expect_entry("R11", 3, 6, 32'h0, 32'h0);
    endtask

    task automatic t_collision();
        cap(0, 0, 64'h0000_0010_0000_0001);
        @(negedge clk);
        cap_en = 1'b1; cap_port = 2'd0; cap_slot = 3'd0;
        cap_timer = 64'h0000_0020_0000_0002;
        host_wr = 1'b1; host_addr = hi_a(0, 0); host_wdata = 32'h0;
        @(negedge clk);
        cap_en = 1'b0; host_wr = 1'b0; cap_timer = '0;
        expect_entry("R10", 0, 0, 32'h0000_0002, 32'h0000_0320);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture_basic();
        t_isolation();
        t_read_hold();
        t_overrun();
        t_nonzero_write();
        t_clear_lo();
        t_clear_hi();
        t_boundary();
        t_collision();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule